// File: doc/BRIEF.md
# Multidrop Serial Receiver with Dormant Mode

This block receives asynchronous serial frames on one line shared by several receivers. A start bit (0) begins each frame. Data bits follow, least significant first, and a stop bit (1) ends it. Each bit lasts sixteen strobes of an oversampling tick supplied from outside. The received word goes to a data register, and a set of status flags reports on each frame: ready, idle line, overrun, noise, framing error and parity error.

Software can put the receiver into a dormant state by writing the `sleep` bit. While it is dormant, the receiver still decodes the line but raises no status flag. Hardware clears `sleep` when a new message begins, and `wake_sel` picks how that is detected:

- **Idle-line mode** (`wake_sel`=0): the line stays at 1 for a full frame time after a received frame.
- **Address-mark mode** (`wake_sel`=1): a frame arrives whose most significant data bit is 1. The waking frame is delivered to software like any other frame.

Top module: `uart_rx_wake`

## Requirements
- R1: While `sleep` is 1, none of `rdy`, `idle`, `ovr`, `noise`, `ferr`, `perr` becomes set. A frame that arrives while dormant leaves `rx_data` unchanged. The one exception is the waking address frame of R4.
- R2: A cycle with `sleep_wr`=1 loads `sleep_wdata` into `sleep` on the next edge. A write of 0 clears it and a write of 1 sets it.
- R3: With `wake_sel`=0, hardware clears `sleep` once the line has been held at 1 for (bits+2)×16 ticks after a received frame. Before that time has elapsed, `sleep` stays 1.
- R4: With `wake_sel`=1, a dormant receiver ignores frames whose MSB is 0. A frame with MSB 1 clears `sleep`, is loaded into `rx_data`, and sets `rdy`. The idle line does not wake the receiver in this mode.
- R5: With `len9`=0 a frame has 8 data bits, and `rx_data[8]` reads 0. With `len9`=1 it has 9 data bits. Bit 0 is received first.
- R6: While awake, `idle` is set after (bits+2)×16 ticks of 1 on the line following a received frame. The idle detector re-arms only after a valid start bit, so a line that stays high sets `idle` once.
- R7: Each bit is the majority of samples 7, 8 and 9 of its 16. If any of the three samples disagree in any bit of a frame, `noise` is set with that frame.
- R8: A stop bit that votes 0 sets `ferr` with the frame.
- R9: A frame that completes while `rdy` is still 1 sets `ovr`. In that case `rx_data` keeps the earlier word.
- R10: With `par_en`=1, the MSB is a parity bit, and `perr` is set when the XOR of all data bits differs from `par_odd` (0 = even parity).
- R11: A `stat_rd` pulse followed by a `data_rd` pulse clears all six flags. A `data_rd` pulse with no preceding `stat_rd` clears none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling strobe, 16 per bit |
| rxd | input | 1 | Serial line, idle high |
| wake_sel | input | 1 | 0 = idle-line wake, 1 = address-mark wake |
| len9 | input | 1 | 0 = 8 data bits, 1 = 9 data bits |
| par_en | input | 1 | MSB is a parity bit |
| par_odd | input | 1 | Parity sense, 1 = odd |
| sleep_wr | input | 1 | Write strobe for the dormant bit |
| sleep_wdata | input | 1 | Value written to the dormant bit |
| stat_rd | input | 1 | Status-read strobe |
| data_rd | input | 1 | Data-read strobe |
| sleep | output | 1 | Dormant bit |
| rx_data | output | 9 | Last accepted word |
| rdy | output | 1 | Data ready |
| idle | output | 1 | Idle line detected |
| ovr | output | 1 | Overrun |
| noise | output | 1 | Noise detected |
| ferr | output | 1 | Framing error |
| perr | output | 1 | Parity error |

## Verification

The assertions check four things on every cycle:

- A flag rises only while the receiver is awake or at the moment it wakes.
- Software writes to the dormant bit take effect on the next edge.
- An idle wake happens only with the line high, and an address wake leaves a marked word and `rdy` set.
- `rx_data` changes only together with `rdy`, and never on an overrun.

Some behaviours depend on whole frames driven onto the line, so only the bench scenarios can show them:

- the idle-time threshold and its re-arming;
- majority voting under a glitch;
- the parity and framing results;
- the order of the status and data reads.

// File: rtl/uart_rx_wake.sv
module uart_rx_wake #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       wake_sel,
  input  logic       len9,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       sleep_wr,
  input  logic       sleep_wdata,
  input  logic       stat_rd,
  input  logic       data_rd,
  output logic       sleep,
  output logic [8:0] rx_data,
  output logic       rdy,
  output logic       idle,
  output logic       ovr,
  output logic       noise,
  output logic       ferr,
  output logic       perr
);
  localparam int CW  = $clog2(OVS);
  localparam int IW  = $clog2(11 * OVS + 1);
  localparam logic [CW-1:0] P_A   = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] P_B   = CW'(OVS / 2);
  localparam logic [CW-1:0] P_C   = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] P_END = CW'(OVS - 1);

  typedef enum logic [1:0] {S_WAIT, S_START, S_DATA, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] ph;
  logic [3:0]    bidx;
  logic [8:0]    sh;
  logic          s_a, s_b, nz;
  logic          armed, rd_arm;
  logic [IW-1:0] icnt;

  wire at_dec = tick16 && st != S_WAIT && ph == P_C;
  wire at_end = tick16 && st != S_WAIT && ph == P_END;
  wire vote   = (s_a & s_b) | (s_a & rxd) | (s_b & rxd);
  wire split  = !((s_a == s_b) && (s_b == rxd));
  wire [3:0] nb = len9 ? 4'd9 : 4'd8;
  wire last   = bidx == nb - 4'd1;

  wire [IW-1:0] ith = len9 ? IW'(11 * OVS) : IW'(10 * OVS);

  wire       done     = at_dec && st == S_STOP;
  wire       start_ok = at_dec && st == S_START && !vote;
  wire [8:0] fdat     = len9 ? sh : {1'b0, sh[7:0]};
  wire       msb      = len9 ? sh[8] : sh[7];
  wire       fnoise   = nz | split;
  wire       par_bad  = par_en && ((^fdat) != par_odd);

  wire idle_hit = tick16 && armed && st == S_WAIT && rxd && icnt == ith - IW'(1);
  wire mark     = done && wake_sel && msb;
  wire accept   = done && (!sleep || mark);
  wire hw_wake  = sleep && (mark || (idle_hit && !wake_sel));
  wire clr      = data_rd && rd_arm;
  wire rdy_left = rdy && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_WAIT;
      ph   <= '0;
      bidx <= '0;
      sh   <= '0;
      s_a  <= 1'b1;
      s_b  <= 1'b1;
      nz   <= 1'b0;
    end else if (tick16) begin
      if (st == S_WAIT) begin
        if (!rxd) begin
          st <= S_START;
          ph <= CW'(1);
          nz <= 1'b0;
        end
      end else begin
        ph <= (ph == P_END) ? '0 : ph + CW'(1);
        if (ph == P_A) s_a <= rxd;
        if (ph == P_B) s_b <= rxd;
        if (ph == P_C) begin
          nz <= nz | split;
          case (st)
            S_START: if (vote) st <= S_WAIT;
            S_DATA:  sh[bidx] <= vote;
            S_STOP:  st <= S_WAIT;
            default: ;
          endcase
        end
        if (ph == P_END) begin
          if (st == S_START) begin
            st   <= S_DATA;
            bidx <= '0;
          end else if (st == S_DATA) begin
            if (last) st <= S_STOP;
            else      bidx <= bidx + 4'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt  <= '0;
      armed <= 1'b0;
    end else if (tick16) begin
      if (st != S_WAIT || !rxd) icnt <= '0;
      else if (armed)           icnt <= icnt + IW'(1);
      if (start_ok)      armed <= 1'b1;
      else if (idle_hit) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sleep <= 1'b0;
    else if (sleep_wr) sleep <= sleep_wdata;
    else if (hw_wake)  sleep <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_arm <= 1'b0;
    else if (stat_rd) rd_arm <= 1'b1;
    else if (data_rd) rd_arm <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      {rdy, idle, ovr, noise, ferr, perr} <= '0;
    end else begin
      if (clr) {rdy, idle, ovr, noise, ferr, perr} <= '0;
      if (idle_hit && !sleep) idle <= 1'b1;
      if (accept) begin
        if (rdy_left) ovr <= 1'b1;
        else begin
          rx_data <= fdat;
          rdy     <= 1'b1;
          noise   <= fnoise;
          ferr    <= !vote;
          perr    <= par_bad;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_wake_chk.sv
module uart_rx_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rxd,
  input logic       wake_sel,
  input logic       len9,
  input logic       sleep_wr,
  input logic       sleep_wdata,
  input logic       sleep,
  input logic [8:0] rx_data,
  input logic       rdy,
  input logic       idle,
  input logic       ovr,
  input logic       noise,
  input logic       ferr,
  input logic       perr
);
  wire [5:0] flg = {rdy, idle, ovr, noise, ferr, perr};

  a_r1_no_flag_dormant: assert property (@(posedge clk) disable iff (!rst_n)
    ((flg & ~$past(flg)) != 6'd0) |-> (!$past(sleep) || !sleep || $past(sleep_wr)));

  a_r2_write_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_wr && sleep_wdata) |=> sleep);

  a_r2_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_wr && !sleep_wdata) |=> !sleep);

  a_r3_idle_wake_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sleep) && !$past(sleep_wr) && !$past(wake_sel)) |-> $past(rxd));

  a_r4_addr_wake_loads: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sleep) && !$past(sleep_wr) && $past(wake_sel)) |->
      (rdy && (ovr || ($past(len9) ? rx_data[8] : rx_data[7]))));

  a_r9_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> ($stable(rx_data) && rdy));

  a_r5_data_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rdy);
endmodule

bind uart_rx_wake uart_rx_wake_chk u_chk (.*);

// File: tb/test_uart_rx_wake.sv
`timescale 1ns/1ps
module test_uart_rx_wake;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick16 = 1'b1, rxd = 1'b1, wake_sel = 1'b0, len9 = 1'b0;
  logic par_en = 1'b0, par_odd = 1'b0, sleep_wr = 1'b0, sleep_wdata = 1'b0;
  logic stat_rd = 1'b0, data_rd = 1'b0;
  logic sleep, rdy, idle, ovr, noise, ferr, perr;
  logic [8:0] rx_data;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uart_rx_wake i_uart_rx_wake (.*);

  // {len9, par_en, par_odd, stop, data[8:0], exp_ferr, exp_perr}
  localparam logic [14:0] VEC [6] = '{
    {4'b0001, 9'h055, 2'b00},
    {4'b0000, 9'h0A3, 2'b10},
    {4'b1001, 9'h1C4, 2'b00},
    {4'b0101, 9'h003, 2'b00},
    {4'b0101, 9'h007, 2'b01},
    {4'b1111, 9'h101, 2'b01}
  };

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_frame(logic [8:0] d, logic stop, int glitch_bit);
    int n = len9 ? 9 : 8;
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    for (int b = 0; b < n; b++) begin
      rxd = d[b];
      if (b == glitch_bit) begin
        repeat (8) @(negedge clk);
        rxd = ~d[b];
        @(negedge clk);
        rxd = d[b];
        repeat (7) @(negedge clk);
      end else repeat (16) @(negedge clk);
    end
    rxd = stop;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic clear_flags();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
  endtask

  task automatic write_sleep(logic v);
    sleep_wr = 1'b1;
    sleep_wdata = v;
    @(negedge clk);
    sleep_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset flags", {3'b0, rdy, idle, ovr, noise, ferr, perr}, 9'h0);
    check("reset sleep", {8'b0, sleep}, 9'h0);
    check("reset data", rx_data, 9'h0);

    foreach (VEC[i]) begin
      {len9, par_en, par_odd} = VEC[i][14:12];
      send_frame(VEC[i][10:2], VEC[i][11], -1);
      check("R5 data", rx_data, VEC[i][14] ? VEC[i][10:2] : {1'b0, VEC[i][9:2]});
      check("R5 ready", {8'b0, rdy}, 9'h1);
      check("R8 framing", {8'b0, ferr}, {8'b0, VEC[i][1]});
      check("R10 parity", {8'b0, perr}, {8'b0, VEC[i][0]});
      check("R7 clean", {8'b0, noise}, 9'h0);
      clear_flags();
      check("R11 cleared", {3'b0, rdy, idle, ovr, noise, ferr, perr}, 9'h0);
      repeat (20) @(negedge clk);
    end
    {len9, par_en, par_odd} = 3'b000;

    repeat (200) @(negedge clk);
    check("R6 idle set", {8'b0, idle}, 9'h1);
    clear_flags();
    repeat (300) @(negedge clk);
    check("R6 not rearmed", {8'b0, idle}, 9'h0);

    send_frame(9'h033, 1'b1, -1);
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
    check("R11 data read alone", {8'b0, rdy}, 9'h1);
    clear_flags();
    check("R11 status then data", {8'b0, rdy}, 9'h0);
    repeat (20) @(negedge clk);

    send_frame(9'h011, 1'b1, -1);
    repeat (20) @(negedge clk);
    send_frame(9'h022, 1'b1, -1);
    check("R9 overrun", {8'b0, ovr}, 9'h1);
    check("R9 data kept", rx_data, 9'h011);
    clear_flags();
    repeat (20) @(negedge clk);

    send_frame(9'h05A, 1'b1, 3);
    check("R7 noise", {8'b0, noise}, 9'h1);
    check("R7 vote", rx_data, 9'h05A);
    repeat (200) @(negedge clk);
    clear_flags();

    write_sleep(1'b1);
    check("R2 set", {8'b0, sleep}, 9'h1);
    write_sleep(1'b0);
    check("R2 clear", {8'b0, sleep}, 9'h0);

    wake_sel = 1'b0;
    write_sleep(1'b1);
    send_frame(9'h044, 1'b0, -1);
    check("R1 no flags dormant", {3'b0, rdy, idle, ovr, noise, ferr, perr}, 9'h0);
    check("R1 data unchanged", rx_data, 9'h05A);
    repeat (100) @(negedge clk);
    check("R3 still dormant", {8'b0, sleep}, 9'h1);
    repeat (100) @(negedge clk);
    check("R3 idle wake", {8'b0, sleep}, 9'h0);
    check("R1 no idle flag", {8'b0, idle}, 9'h0);

    wake_sel = 1'b1;
    write_sleep(1'b1);
    send_frame(9'h012, 1'b1, -1);
    check("R4 data frame ignored", {8'b0, rdy}, 9'h0);
    repeat (200) @(negedge clk);
    check("R4 idle no wake", {8'b0, sleep}, 9'h1);
    check("R1 idle inhibited", {8'b0, idle}, 9'h0);
    send_frame(9'h085, 1'b1, -1);
    check("R4 address wake", {8'b0, sleep}, 9'h0);
    check("R4 address ready", {8'b0, rdy}, 9'h1);
    check("R4 address data", rx_data, 9'h085);
    clear_flags();
    repeat (20) @(negedge clk);

    len9 = 1'b1;
    write_sleep(1'b1);
    send_frame(9'h0FF, 1'b1, -1);
    check("R4 nine-bit unmarked", {8'b0, sleep}, 9'h1);
    repeat (20) @(negedge clk);
    send_frame(9'h100, 1'b1, -1);
    check("R4 nine-bit wake", {8'b0, sleep}, 9'h0);
    check("R5 nine-bit data", rx_data, 9'h100);
    clear_flags();

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule